// File: doc/BRIEF.md
# Dual Data Pointer Unit

This unit sits beside an 8-bit microcontroller core and holds two 16-bit data pointers. At any time exactly one of them is active. Bit 0 of a selection register in the special-function register (SFR) space chooses it. The core changes the active pointer with two commands: increment it, or load it with a 16-bit immediate. The core can also read and write either byte of the active pointer through the SFR port.

The active pointer drives the external data address. A registered adder sums the active pointer and the unsigned accumulator to form the target for code-byte reads and indirect jumps. A second control register in SFR space holds one flag, which tells the address-latch generator to keep its strobe quiet.

The selection register has a hardwired-zero bit 2. Software can therefore read the register, add one and write the result back. This toggles the pointer select without disturbing the two stored control bits at positions 3 and 4.

Top module: `dual_ptr_unit`

## Requirements
- R1: After synchronous reset, both pointers, the select bit, the control bits and the ALE-off flag are 0. `sfr_rdata` reads 00h and `xaddr` reads 0000h.
- R2: Bit 0 of the selection register (SFR 8'hA2) picks the active pointer: 0 selects pointer 0 and 1 selects pointer 1. A write to this register changes the selection from the next cycle on. Commands issued in the same cycle as the write still act on the previously selected pointer.
- R3: The selection register stores bits 0, 3 and 4. Bits 7:5, 2 and 1 always read 0, and writes to them are ignored. Writing back the value read plus one toggles bit 0 and keeps bits 3 and 4.
- R4: SFR 8'h82 accesses the low byte and SFR 8'h83 the high byte of the active pointer. A read returns the value on `sfr_rdata` one cycle after the address is presented.
- R5: `cmd_inc` adds 1 to the active pointer modulo 2^16, so FFFFh wraps to 0000h. The other pointer is unchanged.
- R6: `cmd_load` writes `load_val` into the active pointer only. When `cmd_load` and `cmd_inc` are both high in one cycle, the load wins.
- R7: When a command and an SFR byte write to the active pointer occur in the same cycle, the command takes effect and the byte write is dropped.
- R8: `xaddr` always equals the currently active pointer.
- R9: One cycle after any cycle, `code_addr` equals (`xaddr` + `acc`) mod 2^16 from that cycle, with `acc` taken as unsigned.
- R10: Bit 0 of the control register (SFR 8'h8E) drives `ale_off`. The other bits of that register read 0.
- R11: An SFR address outside 82h, 83h, 8Eh and A2h reads as 00h, and writing to it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_we | input | 1 | SFR write strobe |
| sfr_addr | input | 8 | SFR address for read and write |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | Registered SFR read data |
| cmd_inc | input | 1 | Increment the active pointer |
| cmd_load | input | 1 | Load the active pointer with `load_val` |
| load_val | input | 16 | Immediate for the load command |
| acc | input | 8 | Accumulator value for the code address sum |
| xaddr | output | 16 | External data address (active pointer) |
| code_addr | output | 16 | Registered active pointer plus accumulator |
| ale_off | output | 1 | Flag that requests the ALE output be disabled |

## Verification
The bench builds the unit with its default parameters: 16-bit pointers, 8-bit data and the four default SFR addresses. With these values the wrap from FFFFh to 0000h is only one load and one increment away, and an accumulator of FFh together with a high pointer makes the code-address sum overflow. The 8-bit address lets the bench reach unmapped addresses directly. The read-plus-one toggle is driven on stored select values of both parities, including a value whose carry lands on an unimplemented bit.

// File: rtl/dual_ptr_pkg.sv
package dual_ptr_pkg;
  localparam int NPTR  = 2;
  localparam int SEL_W = 1;

  typedef enum logic [2:0] {
    HIT_NONE,
    HIT_PLO,
    HIT_PHI,
    HIT_SEL,
    HIT_CTL
  } sfr_hit_e;
endpackage

// File: rtl/dptr_bank.sv
module dptr_bank
  import dual_ptr_pkg::*;
#(
  parameter int PTR_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [SEL_W-1:0]            sel,
  input  logic                        cmd_inc,
  input  logic                        cmd_load,
  input  logic [PTR_W-1:0]            load_val,
  input  logic                        wr_lo,
  input  logic                        wr_hi,
  input  logic [DATA_W-1:0]           wdata,
  output logic [NPTR-1:0][PTR_W-1:0]  ptr_q
);
  localparam int HI_W = PTR_W - DATA_W;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    logic [PTR_W-1:0] val_r;
    logic             active;

    assign active = (sel == SEL_W'(g));

    // core commands outrank SFR byte writes; load outranks increment
    always_ff @(posedge clk) begin
      if (rst) begin
        val_r <= '0;
      end else if (active) begin
        if (cmd_load)       val_r <= load_val;
        else if (cmd_inc)   val_r <= val_r + PTR_W'(1);
        else if (wr_lo)     val_r <= {val_r[PTR_W-1:DATA_W], wdata};
        else if (wr_hi)     val_r <= {wdata[HI_W-1:0], val_r[DATA_W-1:0]};
      end
    end

    assign ptr_q[g] = val_r;
  end
endmodule

// File: rtl/dptr_aux_regs.sv
module dptr_aux_regs
  import dual_ptr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_sel,
  input  logic              we_ctl,
  input  logic [DATA_W-1:0] wdata,
  output logic [SEL_W-1:0]  sel,
  output logic [DATA_W-1:0] sel_img,
  output logic [DATA_W-1:0] ctl_img,
  output logic              ale_off
);
  logic       sel_r;
  logic [1:0] ctl_bits_r;
  logic       ale_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_r      <= 1'b0;
      ctl_bits_r <= 2'b00;
      ale_r      <= 1'b0;
    end else begin
      if (we_sel) begin
        sel_r      <= wdata[0];
        ctl_bits_r <= wdata[4:3];
      end
      if (we_ctl) begin
        ale_r <= wdata[0];
      end
    end
  end

  // bit 2 is hardwired low so read+1 carries no further than bit 1
  always_comb begin
    sel_img      = '0;
    sel_img[0]   = sel_r;
    sel_img[4:3] = ctl_bits_r;
    ctl_img      = '0;
    ctl_img[0]   = ale_r;
  end

  assign sel     = sel_r;
  assign ale_off = ale_r;
endmodule

// File: rtl/dptr_code_adder.sv
module dptr_code_adder #(
  parameter int PTR_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic [PTR_W-1:0]  base,
  input  logic [DATA_W-1:0] acc,
  output logic [PTR_W-1:0]  code_addr
);
  always_ff @(posedge clk) begin
    code_addr <= base + PTR_W'(acc);
  end
endmodule

// File: rtl/dual_ptr_unit.sv
module dual_ptr_unit
  import dual_ptr_pkg::*;
#(
  parameter int                PTR_W   = 16,
  parameter int                DATA_W  = 8,
  parameter int                ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] ADR_PLO = 8'h82,
  parameter logic [ADDR_W-1:0] ADR_PHI = 8'h83,
  parameter logic [ADDR_W-1:0] ADR_CTL = 8'h8E,
  parameter logic [ADDR_W-1:0] ADR_SEL = 8'hA2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sfr_we,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  output logic [DATA_W-1:0] sfr_rdata,
  input  logic              cmd_inc,
  input  logic              cmd_load,
  input  logic [PTR_W-1:0]  load_val,
  input  logic [DATA_W-1:0] acc,
  output logic [PTR_W-1:0]  xaddr,
  output logic [PTR_W-1:0]  code_addr,
  output logic              ale_off
);
  localparam int HI_W = PTR_W - DATA_W;

  sfr_hit_e                   hit;
  logic [SEL_W-1:0]           sel;
  logic [NPTR-1:0][PTR_W-1:0] ptr_q;
  logic [DATA_W-1:0]          sel_img;
  logic [DATA_W-1:0]          ctl_img;

  always_comb begin
    hit = HIT_NONE;
    if      (sfr_addr == ADR_PLO) hit = HIT_PLO;
    else if (sfr_addr == ADR_PHI) hit = HIT_PHI;
    else if (sfr_addr == ADR_SEL) hit = HIT_SEL;
    else if (sfr_addr == ADR_CTL) hit = HIT_CTL;
  end

  dptr_bank #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .cmd_inc  (cmd_inc),
    .cmd_load (cmd_load),
    .load_val (load_val),
    .wr_lo    (sfr_we && hit == HIT_PLO),
    .wr_hi    (sfr_we && hit == HIT_PHI),
    .wdata    (sfr_wdata),
    .ptr_q    (ptr_q)
  );

  dptr_aux_regs #(.DATA_W(DATA_W)) u_aux (
    .clk     (clk),
    .rst     (rst),
    .we_sel  (sfr_we && hit == HIT_SEL),
    .we_ctl  (sfr_we && hit == HIT_CTL),
    .wdata   (sfr_wdata),
    .sel     (sel),
    .sel_img (sel_img),
    .ctl_img (ctl_img),
    .ale_off (ale_off)
  );

  assign xaddr = ptr_q[sel];

  dptr_code_adder #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_add (
    .clk       (clk),
    .base      (xaddr),
    .acc       (acc),
    .code_addr (code_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sfr_rdata <= '0;
    end else begin
      unique case (hit)
        HIT_PLO: sfr_rdata <= xaddr[DATA_W-1:0];
        HIT_PHI: sfr_rdata <= DATA_W'(xaddr[PTR_W-1:PTR_W-HI_W]);
        HIT_SEL: sfr_rdata <= sel_img;
        HIT_CTL: sfr_rdata <= ctl_img;
        default: sfr_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dual_ptr_unit_chk.sv
module dual_ptr_unit_chk #(
  parameter int                PTR_W   = 16,
  parameter int                DATA_W  = 8,
  parameter int                ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] ADR_PLO = 8'h82,
  parameter logic [ADDR_W-1:0] ADR_PHI = 8'h83,
  parameter logic [ADDR_W-1:0] ADR_CTL = 8'h8E,
  parameter logic [ADDR_W-1:0] ADR_SEL = 8'hA2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    sfr_we,
  input logic [ADDR_W-1:0]       sfr_addr,
  input logic [DATA_W-1:0]       sfr_wdata,
  input logic [DATA_W-1:0]       sfr_rdata,
  input logic                    cmd_inc,
  input logic                    cmd_load,
  input logic [PTR_W-1:0]        load_val,
  input logic [DATA_W-1:0]       acc,
  input logic [PTR_W-1:0]        xaddr,
  input logic [PTR_W-1:0]        code_addr,
  input logic                    ale_off,
  input logic [1:0][PTR_W-1:0]   ptr_q,
  input logic                    sel
);
  localparam logic [DATA_W-1:0] SEL_ZERO = ~DATA_W'(8'h19);

  logic sel_wr;
  logic mapped;
  assign sel_wr = sfr_we && (sfr_addr == ADR_SEL);
  assign mapped = (sfr_addr == ADR_PLO) || (sfr_addr == ADR_PHI) ||
                  (sfr_addr == ADR_SEL) || (sfr_addr == ADR_CTL);

  AST_SEL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    sel_wr |=> sel == $past(sfr_wdata[0])); // R2

  AST_SEL_ZERO_BITS: assert property (@(posedge clk) disable iff (rst)
    (sfr_addr == ADR_SEL) |=> (sfr_rdata & SEL_ZERO) == '0); // R3

  AST_INC_STEP: assert property (@(posedge clk) disable iff (rst)
    (cmd_inc && !cmd_load && !sel_wr) |=> xaddr == PTR_W'($past(xaddr) + 1'b1)); // R5

  AST_OTHER_KEEP: assert property (@(posedge clk) disable iff (rst)
    (cmd_inc || cmd_load) |=> ptr_q[~$past(sel)] == $past(ptr_q[~sel])); // R5

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    (cmd_load && !sel_wr) |=> xaddr == $past(load_val)); // R6

  AST_CMD_OVER_BYTE: assert property (@(posedge clk) disable iff (rst)
    (cmd_load && sfr_we && (sfr_addr == ADR_PLO || sfr_addr == ADR_PHI))
      |=> xaddr == $past(load_val)); // R7

  AST_CODE_SUM: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> code_addr == PTR_W'($past(xaddr) + PTR_W'($past(acc)))); // R9

  AST_ALE_FLAG: assert property (@(posedge clk) disable iff (rst)
    (sfr_we && sfr_addr == ADR_CTL) |=> ale_off == $past(sfr_wdata[0])); // R10

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    !mapped |=> sfr_rdata == '0); // R11
endmodule

bind dual_ptr_unit dual_ptr_unit_chk #(
  .PTR_W(PTR_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .ADR_PLO(ADR_PLO), .ADR_PHI(ADR_PHI), .ADR_CTL(ADR_CTL), .ADR_SEL(ADR_SEL)
) u_chk (.*);

// File: tb/test_dual_ptr_unit.sv
module test_dual_ptr_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sfr_we = 1'b0;
  logic [7:0]  sfr_addr = 8'h00;
  logic [7:0]  sfr_wdata = 8'h00;
  logic [7:0]  sfr_rdata;
  logic        cmd_inc = 1'b0;
  logic        cmd_load = 1'b0;
  logic [15:0] load_val = 16'h0000;
  logic [7:0]  acc = 8'h00;
  logic [15:0] xaddr;
  logic [15:0] code_addr;
  logic        ale_off;

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  string cur_req = "R8";

  // behavioural reference state
  logic [15:0] m_p [2];
  logic        m_sel, m_b3, m_b4, m_ale;
  logic [7:0]  e_rd, rd_addr;
  logic [15:0] e_code;

  always #10 clk = ~clk;

  dual_ptr_unit i_dual_ptr_unit (
    .clk(clk), .rst(rst), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .cmd_inc(cmd_inc),
    .cmd_load(cmd_load), .load_val(load_val), .acc(acc), .xaddr(xaddr),
    .code_addr(code_addr), .ale_off(ale_off)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    if (rst) begin
      m_p[0] = 0; m_p[1] = 0; m_sel = 0; m_b3 = 0; m_b4 = 0; m_ale = 0;
      e_rd = 0; rd_addr = 8'h00;
      return;
    end
    rd_addr = sfr_addr;
    case (sfr_addr)
      8'h82:   e_rd = m_p[m_sel] % 256;
      8'h83:   e_rd = m_p[m_sel] / 256;
      8'hA2:   e_rd = {3'b000, m_b4, m_b3, 2'b00, m_sel};
      8'h8E:   e_rd = {7'b0, m_ale};
      default: e_rd = 8'h00;
    endcase
    e_code = 16'((int'(m_p[m_sel]) + int'(acc)) % 65536);
    if (cmd_load)       m_p[m_sel] = load_val;
    else if (cmd_inc)   m_p[m_sel] = 16'((int'(m_p[m_sel]) + 1) % 65536);
    else if (sfr_we && sfr_addr == 8'h82) m_p[m_sel] = {m_p[m_sel][15:8], sfr_wdata};
    else if (sfr_we && sfr_addr == 8'h83) m_p[m_sel] = {sfr_wdata, m_p[m_sel][7:0]};
    if (sfr_we && sfr_addr == 8'hA2) begin
      m_sel = sfr_wdata[0]; m_b3 = sfr_wdata[3]; m_b4 = sfr_wdata[4];
    end
    if (sfr_we && sfr_addr == 8'h8E) m_ale = sfr_wdata[0];
  endtask

  task automatic compare_all();
    string rq;
    if (rst) return;
    chk(cur_req, "xaddr", 32'(xaddr), 32'(m_p[m_sel]));
    chk("R9", "code_addr", 32'(code_addr), 32'(e_code));
    chk("R10", "ale_off", 32'(ale_off), 32'(m_ale));
    case (rd_addr)
      8'h82, 8'h83: rq = "R4";
      8'hA2:        rq = "R3";
      8'h8E:        rq = "R10";
      default:      rq = "R11";
    endcase
    chk(rq, "sfr_rdata", 32'(sfr_rdata), 32'(e_rd));
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic drive(bit we, logic [7:0] ad, logic [7:0] wd, bit inc, bit ld,
                       logic [15:0] lv, logic [7:0] ac);
    sfr_we = we; sfr_addr = ad; sfr_wdata = wd;
    cmd_inc = inc; cmd_load = ld; load_val = lv; acc = ac;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] pick [5] = '{8'h82, 8'h83, 8'hA2, 8'h8E, 8'h5C};
    @(negedge clk);
    repeat (3) tick();
    rst = 1'b0;
    // R1 reset state observed at the ports
    chk("R1", "xaddr", 32'(xaddr), 0);
    chk("R1", "sfr_rdata", 32'(sfr_rdata), 0);
    chk("R1", "ale_off", 32'(ale_off), 0);
    cur_req = "R1";
    drive(0, 8'hA2, 0, 0, 0, 0, 0);
    drive(0, 8'h8E, 0, 0, 0, 0, 0);
    // R4 byte writes and reads of pointer 0
    cur_req = "R4";
    drive(1, 8'h82, 8'h34, 0, 0, 0, 0);
    drive(1, 8'h83, 8'h12, 0, 0, 0, 0);
    drive(0, 8'h82, 0, 0, 0, 0, 0);
    drive(0, 8'h83, 0, 0, 0, 0, 0);
    chk("R4", "high byte read", 32'(sfr_rdata), 32'h12);
    // R5 increment and wrap
    cur_req = "R5";
    drive(0, 8'h00, 0, 1, 0, 0, 0);
    drive(0, 8'h00, 0, 0, 1, 16'hFFFF, 0);
    drive(0, 8'h00, 0, 1, 0, 0, 0);
    chk("R5", "wrap", 32'(xaddr), 0);
    drive(0, 8'h00, 0, 0, 1, 16'h00FF, 0);
    drive(0, 8'h00, 0, 1, 0, 0, 0);
    // R2 select write; same-cycle increment hits old pointer
    cur_req = "R2";
    drive(1, 8'hA2, 8'h01, 1, 0, 0, 0);
    chk("R2", "pointer 1 selected", 32'(xaddr), 0);
    // R6 load beats increment, pointer 0 untouched
    cur_req = "R6";
    drive(0, 8'h00, 0, 1, 1, 16'hABCD, 0);
    chk("R6", "load wins", 32'(xaddr), 32'hABCD);
    drive(1, 8'hA2, 8'h00, 0, 0, 0, 0);
    chk("R6", "pointer 0 kept", 32'(xaddr), 32'h0101);
    // R7 command over byte write
    cur_req = "R7";
    drive(1, 8'h82, 8'h77, 1, 0, 0, 0);
    drive(1, 8'h83, 8'h99, 0, 1, 16'h4242, 0);
    chk("R7", "load over byte write", 32'(xaddr), 32'h4242);
    // R3 stored bits, zero bits, read-plus-one toggle
    cur_req = "R3";
    drive(1, 8'hA2, 8'hFF, 0, 0, 0, 0);
    drive(0, 8'hA2, 0, 0, 0, 0, 0);
    chk("R3", "image", 32'(sfr_rdata), 32'h19);
    for (int k = 0; k < 4; k++) begin
      drive(0, 8'hA2, 0, 0, 0, 0, 0);
      v = sfr_rdata;
      drive(1, 8'hA2, v + 8'd1, 0, 0, 0, 0);
    end
    drive(0, 8'hA2, 0, 0, 0, 0, 0);
    chk("R3", "after four toggles", 32'(sfr_rdata), 32'h19);
    drive(1, 8'hA2, 8'h00, 0, 0, 0, 0);
    // R9 code address sums with overflow
    cur_req = "R8";
    drive(0, 8'h00, 0, 0, 1, 16'hFFF0, 8'hFF);
    drive(0, 8'h00, 0, 0, 0, 0, 8'hFF);
    drive(0, 8'h00, 0, 0, 0, 0, 8'h10);
    drive(0, 8'h00, 0, 0, 0, 0, 8'h00);
    // R10 control register
    drive(1, 8'h8E, 8'hFF, 0, 0, 0, 0);
    chk("R10", "ale_off set", 32'(ale_off), 1);
    drive(0, 8'h8E, 0, 0, 0, 0, 0);
    drive(1, 8'h8E, 8'hFE, 0, 0, 0, 0);
    chk("R10", "ale_off clear", 32'(ale_off), 0);
    // R11 unmapped address write and read
    cur_req = "R11";
    drive(1, 8'h90, 8'hFF, 0, 0, 0, 0);
    drive(0, 8'h90, 0, 0, 0, 0, 0);
    chk("R11", "unmapped read", 32'(sfr_rdata), 0);
    drive(0, 8'hA2, 0, 0, 0, 0, 0);
    chk("R11", "select unchanged", 32'(sfr_rdata), 0);
    // mixed traffic against the reference
    cur_req = "R8";
    for (int n = 0; n < 400; n++) begin
      drive(1'($urandom_range(0, 1)), pick[$urandom_range(0, 4)], 8'($urandom),
            ($urandom_range(0, 3) == 0), ($urandom_range(0, 7) == 0),
            16'($urandom), 8'($urandom));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule